// File: doc/BRIEF.md
# Parallel NOR flash identification probe

This block learns which byte-wide NOR flash sits behind a simple synchronous flash port. Right after reset, and again whenever `start_i` is pulsed while it is idle, it writes the identify command, waits a fixed settling time, and reads a high ID byte and a low ID byte. It then joins them into a 16-bit identifier and puts the array back into read mode. From the identifier it reports which of two known array sizes is fitted, or that the part is unknown.

One part of the sequence depends on data. The low byte is read from offset 2 when the high byte is 0xB0, and from offset 1 for any other high byte. The wait is counted in clock cycles and is computed from the clock frequency and the required time in microseconds.

The flash port is a one-cycle command or read cycle. A read strobe in one cycle returns data on `fl_rdata_i` in the next cycle.

Top module: `flash_id_probe`

## Requirements
- R1: The first bus operation of each probe is a one-cycle write of 0x90 to offset 0x8000. It is issued in the cycle after the start is taken.
- R2: The first read strobe comes exactly CLK_MHZ*WAIT_US+1 cycles after the identify write. No read strobe is issued before it.
- R3: The first read is at offset 0, and the byte it returns is the high ID byte.
- R4: The second read is at offset 2 when the high byte equals 0xB0, and at offset 1 otherwise. It comes two cycles after the first read.
- R5: `id_o` equals the high byte times 256 plus the low byte.
- R6: Two cycles after the second read, a one-cycle write of 0xFF to offset 0x8000 returns the array to read mode. It is the fourth and last bus operation of the probe.
- R7: `size_sel_o` is 2'b10 for ID 0xB0D4, 2'b01 for ID 0x89A6, and 2'b00 for any other ID. This includes an ID whose high byte is 0xB0 but whose low byte is not 0xD4.
- R8: `done_o` is high for exactly one cycle, the cycle after the read-mode write. `id_valid_o` rises in that same cycle and holds with a stable `id_o` until the next start is taken, when it drops. Both are low out of reset.
- R9: A probe runs by itself once after reset, without `start_i`.
- R10: `start_i` while a probe is in progress has no effect: no extra operations, and no extra `done_o` pulse.
- R11: Write and read strobes are never high in the same cycle. A write only ever targets offset 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a probe when idle |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Command byte |
| fl_we_o | output | 1 | Write strobe |
| fl_re_o | output | 1 | Read strobe |
| fl_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| id_o | output | 16 | Combined identifier |
| id_valid_o | output | 1 | Identifier and size valid |
| size_sel_o | output | 2 | 2'b01 = 1 MiB, 2'b10 = 4 MiB, 2'b00 = unknown |
| done_o | output | 1 | One-cycle end-of-probe pulse |

## Verification
The hardest case to reach is the data-dependent choice of the second read address. It must be shown that offset 2 is taken only for a 0xB0 high byte, including the near miss where 0xB0 is followed by the wrong low byte. The bench's flash model therefore holds different bytes at offsets 1 and 2, and it answers with ID bytes only while its identify mode is entered. A wrong address or a missed mode change then shows up as a wrong identifier. Start pulses are also injected during the settling wait, to show that a probe in progress cannot be restarted or queued.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam logic [7:0]  CMD_IDENT = 8'h90;
  localparam logic [7:0]  CMD_READ  = 8'hFF;
  localparam logic [7:0]  WIDE_MFR  = 8'hB0;
  localparam logic [15:0] CMD_OFS   = 16'h8000;
  localparam logic [15:0] ID_4M     = 16'hB0D4;
  localparam logic [15:0] ID_1M     = 16'h89A6;

  typedef enum logic [1:0] {
    SZ_UNKNOWN = 2'b00,
    SZ_1M      = 2'b01,
    SZ_4M      = 2'b10
  } size_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_WAIT, ST_RD_HI, ST_CAP_HI,
    ST_RD_LO, ST_CAP_LO, ST_EXIT, ST_FIN
  } state_e;
endpackage

// File: rtl/flash_id_timer.sv
module flash_id_timer #(
  parameter int unsigned WAIT_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  localparam int unsigned CW = $clog2(WAIT_CYC) + 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= LOAD_VAL;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_id_pkg::*;
(
  input  logic [7:0]  hi_i,
  input  logic [15:0] id_i,
  output logic [1:0]  lo_ofs_o,
  output logic [1:0]  size_o
);
  // low byte position depends on the high byte
  assign lo_ofs_o = (hi_i == WIDE_MFR) ? 2'd2 : 2'd1;

  always_comb begin
    unique case (id_i)
      ID_4M:   size_o = SZ_4M;
      ID_1M:   size_o = SZ_1M;
      default: size_o = SZ_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq
  import flash_id_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wait_zero_i,
  output logic              wait_load_o,
  output logic              wait_en_o,
  input  logic [1:0]        lo_ofs_i,
  input  logic [1:0]        size_i,
  output logic [7:0]        hi_o,
  output logic [15:0]       raw_id_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [7:0]        fl_rdata_i,
  output logic [15:0]       id_o,
  output logic              id_valid_o,
  output logic [1:0]        size_sel_o,
  output logic              done_o
);
  state_e state_q, state_d;
  logic       boot_q;
  logic [7:0] hi_q, lo_q;
  logic [1:0] lo_ofs_q;
  logic       go;

  assign go = boot_q | start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go) state_d = ST_CMD;
      ST_CMD:    state_d = ST_WAIT;
      ST_WAIT:   if (wait_zero_i) state_d = ST_RD_HI;
      ST_RD_HI:  state_d = ST_CAP_HI;
      ST_CAP_HI: state_d = ST_RD_LO;
      ST_RD_LO:  state_d = ST_CAP_LO;
      ST_CAP_LO: state_d = ST_EXIT;
      ST_EXIT:   state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      boot_q     <= 1'b1;
      hi_q       <= '0;
      lo_q       <= '0;
      lo_ofs_q   <= 2'd1;
      id_o       <= '0;
      id_valid_o <= 1'b0;
      size_sel_o <= SZ_UNKNOWN;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) begin
        boot_q     <= 1'b0;
        id_valid_o <= 1'b0;
      end
      if (state_q == ST_CAP_HI) begin
        hi_q <= fl_rdata_i;
      end
      if (state_q == ST_RD_LO) lo_ofs_q <= lo_ofs_i;
      if (state_q == ST_CAP_LO) lo_q <= fl_rdata_i;
      if (state_q == ST_EXIT) begin
        id_o       <= {hi_q, lo_q};
        size_sel_o <= size_i;
        id_valid_o <= 1'b1;
      end
    end
  end

  assign hi_o        = hi_q;
  assign raw_id_o    = {hi_q, lo_q};
  assign wait_load_o = (state_q == ST_CMD);
  assign wait_en_o   = (state_q == ST_WAIT);
  assign done_o      = (state_q == ST_FIN);

  always_comb begin
    fl_addr_o  = '0;
    fl_wdata_o = '0;
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    unique case (state_q)
      ST_CMD: begin
        fl_addr_o  = ADDR_W'(CMD_OFS);
        fl_wdata_o = CMD_IDENT;
        fl_we_o    = 1'b1;
      end
      ST_RD_HI: fl_re_o = 1'b1;
      ST_RD_LO: begin
        fl_addr_o = ADDR_W'(lo_ofs_i);
        fl_re_o   = 1'b1;
      end
      ST_EXIT: begin
        fl_addr_o  = ADDR_W'(CMD_OFS);
        fl_wdata_o = CMD_READ;
        fl_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  logic unused_ofs;
  assign unused_ofs = ^lo_ofs_q;
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WAIT_US = 15,
  parameter int unsigned ADDR_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [7:0]        fl_rdata_i,
  output logic [15:0]       id_o,
  output logic              id_valid_o,
  output logic [1:0]        size_sel_o,
  output logic              done_o
);
  localparam int unsigned WAIT_CYC = (CLK_MHZ * WAIT_US < 1) ? 1 : CLK_MHZ * WAIT_US;

  logic        wait_load, wait_en, wait_zero;
  logic [7:0]  hi;
  logic [15:0] raw_id;
  logic [1:0]  lo_ofs, size;

  flash_id_timer #(.WAIT_CYC(WAIT_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_load),
    .en_i   (wait_en),
    .zero_o (wait_zero)
  );

  flash_id_decode i_decode (
    .hi_i     (hi),
    .id_i     (raw_id),
    .lo_ofs_o (lo_ofs),
    .size_o   (size)
  );

  flash_id_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wait_zero_i (wait_zero),
    .wait_load_o (wait_load),
    .wait_en_o   (wait_en),
    .lo_ofs_i    (lo_ofs),
    .size_i      (size),
    .hi_o        (hi),
    .raw_id_o    (raw_id),
    .fl_addr_o   (fl_addr_o),
    .fl_wdata_o  (fl_wdata_o),
    .fl_we_o     (fl_we_o),
    .fl_re_o     (fl_re_o),
    .fl_rdata_i  (fl_rdata_i),
    .id_o        (id_o),
    .id_valid_o  (id_valid_o),
    .size_sel_o  (size_sel_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/flash_id_checker.sv
module flash_id_checker
  import flash_id_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic              fl_we_o,
  input logic              fl_re_o,
  input logic [7:0]        fl_rdata_i,
  input logic [15:0]       id_o,
  input logic              id_valid_o,
  input logic [1:0]        size_sel_o,
  input logic              done_o
);
  p_excl_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));

  p_we_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> (fl_addr_o == ADDR_W'(CMD_OFS)) &&
                (fl_wdata_o == CMD_IDENT || fl_wdata_o == CMD_READ));

  p_rd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_re_o |-> fl_addr_o < ADDR_W'(3));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_valid_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> id_valid_o);

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_valid_o) |-> done_o);

  p_id_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && $past(id_valid_o)) |-> $stable(id_o));

  p_exit_before_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && fl_wdata_o == CMD_READ) |=> done_o);

  p_size_4m_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && id_o == ID_4M) |-> size_sel_o == SZ_4M);

  p_size_1m_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && id_o == ID_1M) |-> size_sel_o == SZ_1M);

  p_size_unk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && id_o != ID_1M && id_o != ID_4M) |-> size_sel_o == SZ_UNKNOWN);

  logic unused_in;
  assign unused_in = start_i ^ (^fl_rdata_i);
endmodule

bind flash_id_probe flash_id_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .fl_addr_o  (fl_addr_o),
  .fl_wdata_o (fl_wdata_o),
  .fl_we_o    (fl_we_o),
  .fl_re_o    (fl_re_o),
  .fl_rdata_i (fl_rdata_i),
  .id_o       (id_o),
  .id_valid_o (id_valid_o),
  .size_sel_o (size_sel_o),
  .done_o     (done_o)
);

// File: tb/test_flash_id_probe.sv
`timescale 1ns/1ps
module test_flash_id_probe;
  localparam int ADDR_W = 22;
  localparam int W = 200 * 15;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, id_valid, done;
  logic [15:0] id;
  logic [1:0] size_sel;

  always #2.5 clk = ~clk;

  flash_id_probe #(.CLK_MHZ(200), .WAIT_US(15), .ADDR_W(ADDR_W)) i_flash_id_probe (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
    .fl_rdata_i(fl_rdata), .id_o(id), .id_valid_o(id_valid),
    .size_sel_o(size_sel), .done_o(done)
  );

  // flash model: identify mode answers from id bytes, read mode returns 0xEE
  logic [7:0] b0, b1, b2;
  logic id_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_mode  <= 1'b0;
      fl_rdata <= 8'h00;
    end else begin
      if (fl_we && fl_addr == ADDR_W'(16'h8000) && fl_wdata == 8'h90) id_mode <= 1'b1;
      if (fl_we && fl_wdata == 8'hFF) id_mode <= 1'b0;
      if (fl_re) begin
        if (!id_mode)                  fl_rdata <= 8'hEE;
        else if (fl_addr == 0)         fl_rdata <= b0;
        else if (fl_addr == 1)         fl_rdata <= b1;
        else if (fl_addr == 2)         fl_rdata <= b2;
        else                           fl_rdata <= 8'h00;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_ops, done_cnt, done_cyc;
  logic op_we [8];
  int   op_addr [8];
  int   op_data [8];
  int   op_cyc [8];
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_we || fl_re) begin
        if (n_ops < 8) begin
          op_we[n_ops]   = fl_we;
          op_addr[n_ops] = int'(fl_addr);
          op_data[n_ops] = int'(fl_wdata);
          op_cyc[n_ops]  = cyc;
        end
        n_ops = n_ops + 1;
      end
      if (done) begin
        done_cnt = done_cnt + 1;
        done_cyc = cyc;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ops = 0; done_cnt = 0; done_cyc = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < W + 200) begin
      @(negedge clk);
      t++;
    end
    chk("watchdog", int'(done_cnt != 0), 1);
  endtask

  task automatic check_probe(input int lo_addr, input int exp_id, input int exp_size);
    chk("R1 op0 is write", int'(op_we[0]), 1);
    chk("R1 op0 addr", op_addr[0], 'h8000);
    chk("R1 op0 data", op_data[0], 'h90);
    chk("R2 wait gap", op_cyc[1] - op_cyc[0], W + 1);
    chk("R3 op1 read at 0", int'(op_we[1]) * 16 + op_addr[1], 0);
    chk("R4 op2 read addr", int'(op_we[2]) * 16 + op_addr[2], lo_addr);
    chk("R4 op2 timing", op_cyc[2] - op_cyc[1], 2);
    chk("R6 op3 write FF", int'(op_we[3]) * 256 + op_data[3], 256 + 'hFF);
    chk("R6 op3 addr", op_addr[3], 'h8000);
    chk("R6 op3 timing", op_cyc[3] - op_cyc[2], 2);
    chk("R6 model back in read mode", int'(id_mode), 0);
    chk("R8 done after exit", done_cyc - op_cyc[3], 1);
    chk("R5 id", int'(id), exp_id);
    chk("R7 size", int'(size_sel), exp_size);
    chk("R8 id_valid", int'(id_valid), 1);
    repeat (20) @(negedge clk);
    chk("R8 done single pulse", done_cnt, 1);
    chk("R6 four ops only", n_ops, 4);
    chk("R8 id_valid held", int'(id_valid), 1);
    chk("R8 id held", int'(id), exp_id);
  endtask

  task automatic set_dev(input logic [7:0] x0, input logic [7:0] x1, input logic [7:0] x2);
    b0 = x0; b1 = x1; b2 = x2;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 id_valid drops on start", int'(id_valid), 0);
    chk("R1 identify write after start", int'(fl_we) * 256 + int'(fl_wdata), 256 + 'h90);
  endtask

  task automatic t_boot();
    set_dev(8'hB0, 8'h55, 8'hD4);
    clear_log();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset id_valid", int'(id_valid), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R11 reset strobes", int'(fl_we) + int'(fl_re), 0);
    rst_n = 1'b1;
    wait_done();
    check_probe(2, 'hB0D4, 2); // R9 auto-run, 4 MiB part
  endtask

  task automatic t_probe(input logic [7:0] x0, input logic [7:0] x1, input logic [7:0] x2,
                         input int lo_addr, input int exp_id, input int exp_size);
    set_dev(x0, x1, x2);
    clear_log();
    pulse_start();
    wait_done();
    check_probe(lo_addr, exp_id, exp_size);
  endtask

  task automatic t_busy_start();
    set_dev(8'h89, 8'hA6, 8'h33);
    clear_log();
    pulse_start();
    repeat (50) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0; // R10 start while waiting
    repeat (W - 100) @(negedge clk);
    start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;
    wait_done();
    check_probe(1, 'h89A6, 1); // R10 no restart, no queued probe
  endtask

  initial begin
    set_dev(8'h00, 8'h00, 8'h00);
    clear_log();
    t_boot();
    t_probe(8'h89, 8'hA6, 8'h33, 1, 'h89A6, 1);   // R7 1 MiB
    t_probe(8'h12, 8'h34, 8'h56, 1, 'h1234, 0);   // R7 unknown
    t_probe(8'hB0, 8'hD4, 8'h11, 2, 'hB011, 0);   // R4 B0 near miss
    t_probe(8'hB1, 8'hD4, 8'hC0, 1, 'hB1D4, 0);   // R4 non-B0 high byte
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 60000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule